// File: doc/BRIEF.md
# Square-Root Seed Estimator

This block produces a starting estimate for an iterative integer square root of an unsigned operand, 24 bits wide by default. A refinement stage, such as a Newton step built around a divider, takes the estimate as its first guess. A good seed cuts the number of refinement passes that stage needs. The block does not use a lookup table. Instead it counts the leading zeros of the operand one bit per clock. That count gives the significant-bit count K. The block then shifts a fresh copy of the operand right by ceil(K/2) bits, one bit per clock. What remains has about half of the operand's significant bits, which is a coarse estimate of its root.

A one-cycle `start_i` captures the operand. Once the block has captured it, the input bus may change freely. When the estimate is ready, `done_o` pulses for one cycle and `est_o` presents the result. `est_o` then holds that value until the next completion. The run time depends on the data. A zero operand is handled at once, without entering either phase.

Top module: `sqrt_seed_gen`

## Requirements
- R1: After reset, `done_o` is 0 and `est_o` is 0.
- R2: For a nonzero operand a with K significant bits (K is the index of its leading one, plus one), `est_o` = a >> ceil(K/2) at completion.
- R3: A result that would be 0 is raised to 1. This applies only to a = 1, so an operand of 1 yields 1.
- R4: For a nonzero operand, `done_o` rises L = (24 − K) + ceil(K/2) + 2 rising edges after the edge that samples `start_i`. This gives L = 26 for a = 1 and L = 14 for a = 0xFFFFFF.
- R5: For a zero operand, `est_o` becomes 0 and `done_o` rises on the same edge that samples `start_i`.
- R6: `done_o` is high for exactly one cycle per accepted start.
- R7: `start_i` is ignored while a computation is in progress. Neither the result nor the timing of the running computation changes.
- R8: `est_o` changes only on a completion. Changes on `opnd_i` after the start edge do not affect the result.
- R9: `est_o` never exceeds 2^12 − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| opnd_i | input | 24 | Unsigned operand, captured on the start edge |
| est_o | output | 13 | Root estimate, held between completions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the done pulse lasts a single cycle;
- the estimate stays stable outside completions and within its 12-bit range;
- the counting phase never aborts back to idle;
- the shift counter steps down by exactly one per shift.

The exact estimate value, the forcing of 1 for a = 1, and the data-dependent latency can only be shown by the bench. So can the immunity to a second start while busy and to operand changes after capture. The bench covers every single-bit operand, the all-ones and zero operands, and a batch of random values.

// File: rtl/sqe_pkg.sv
package sqe_pkg;
  typedef enum logic [1:0] {WK_HOLD, WK_LOAD, WK_SHL, WK_SHR} work_op_e;
  typedef enum logic [2:0] {CN_HOLD, CN_CLR, CN_INC, CN_LOAD, CN_DEC} cnt_op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_COUNT, ST_SHIFT} state_e;
endpackage

// File: rtl/sqe_work_reg.sv
module sqe_work_reg
  import sqe_pkg::*;
#(
  parameter int unsigned OPW = 24,
  localparam int unsigned WW = OPW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  work_op_e       op_i,
  input  logic           reload_i,
  input  logic [OPW-1:0] opnd_i,
  output logic [WW-1:0]  work_o,
  output logic           msb_o
);
  logic [WW-1:0]  work_q;
  logic [OPW-1:0] opnd_q;
  logic [OPW-1:0] load_val;

  // first load takes the port, second load the captured copy
  assign load_val = reload_i ? opnd_q : opnd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '0;
      opnd_q <= '0;
    end else begin
      if (op_i == WK_LOAD && !reload_i) opnd_q <= opnd_i;
      unique case (op_i)
        WK_LOAD: work_q <= {1'b0, load_val};
        WK_SHL:  work_q <= {work_q[WW-2:0], 1'b0};
        WK_SHR:  work_q <= {1'b0, work_q[WW-1:1]};
        default: work_q <= work_q;
      endcase
    end
  end

  assign work_o = work_q;
  assign msb_o  = work_q[OPW-1];
endmodule

// File: rtl/sqe_counter.sv
module sqe_counter
  import sqe_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cnt_op_e       op_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        CN_CLR:  cnt_q <= '0;
        CN_INC:  cnt_q <= cnt_q + 1'b1;
        CN_LOAD: cnt_q <= load_val_i;
        CN_DEC:  cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sqe_ctrl.sv
module sqe_ctrl
  import sqe_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     opnd_zero_i,
  input  logic     msb_i,
  input  logic     cnt_zero_i,
  output work_op_e work_op_o,
  output logic     reload_o,
  output cnt_op_e  cnt_op_o,
  output logic     est_cap_o,
  output logic     est_clr_o,
  output logic     done_o,
  output state_e   state_o
);
  state_e state_q, state_d;
  logic   done_q, done_d;

  always_comb begin
    state_d   = state_q;
    work_op_o = WK_HOLD;
    reload_o  = 1'b0;
    cnt_op_o  = CN_HOLD;
    est_cap_o = 1'b0;
    est_clr_o = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (opnd_zero_i) begin
            est_clr_o = 1'b1;
            done_d    = 1'b1;
          end else begin
            work_op_o = WK_LOAD;
            cnt_op_o  = CN_CLR;
            state_d   = ST_COUNT;
          end
        end
      end
      ST_COUNT: begin
        if (msb_i) begin
          work_op_o = WK_LOAD;
          reload_o  = 1'b1;
          cnt_op_o  = CN_LOAD;
          state_d   = ST_SHIFT;
        end else begin
          work_op_o = WK_SHL;
          cnt_op_o  = CN_INC;
        end
      end
      ST_SHIFT: begin
        if (cnt_zero_i) begin
          est_cap_o = 1'b1;
          done_d    = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          work_op_o = WK_SHR;
          cnt_op_o  = CN_DEC;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign done_o  = done_q;
  assign state_o = state_q;
endmodule

// File: rtl/sqrt_seed_gen.sv
module sqrt_seed_gen
  import sqe_pkg::*;
#(
  parameter int unsigned OPW  = 24,
  parameter int unsigned ESTW = OPW / 2 + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OPW-1:0]  opnd_i,
  output logic [ESTW-1:0] est_o,
  output logic            done_o
);
  localparam int unsigned WW = OPW + 1;
  localparam int unsigned CW = $clog2(OPW + 1);

  work_op_e      work_op;
  cnt_op_e       cnt_op;
  state_e        state_w;
  logic          reload, msb, cnt_zero, est_cap, est_clr;
  logic [WW-1:0] work;
  logic [CW-1:0] cnt_w, half_cnt;
  logic [CW:0]   sig_bits;
  logic [ESTW-1:0] est_q, est_raw;

  // counter holds leading-zero count when the leading one reaches the top
  assign sig_bits = (CW+1)'(OPW) - {1'b0, cnt_w};
  assign half_cnt = CW'((sig_bits + 1'b1) >> 1);

  sqe_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .opnd_zero_i (opnd_i == '0),
    .msb_i       (msb),
    .cnt_zero_i  (cnt_zero),
    .work_op_o   (work_op),
    .reload_o    (reload),
    .cnt_op_o    (cnt_op),
    .est_cap_o   (est_cap),
    .est_clr_o   (est_clr),
    .done_o      (done_o),
    .state_o     (state_w)
  );

  sqe_work_reg #(.OPW(OPW)) u_work (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (work_op),
    .reload_i (reload),
    .opnd_i   (opnd_i),
    .work_o   (work),
    .msb_o    (msb)
  );

  sqe_counter #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (cnt_op),
    .load_val_i (half_cnt),
    .cnt_o      (cnt_w),
    .zero_o     (cnt_zero)
  );

  assign est_raw = work[ESTW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      est_q <= '0;
    else if (est_clr) est_q <= '0;
    else if (est_cap) est_q <= (est_raw == '0) ? ESTW'(1) : est_raw;
  end

  assign est_o = est_q;
endmodule

// File: rtl/sqe_chk.sv
module sqe_chk
  import sqe_pkg::*;
#(
  parameter int unsigned OPW  = 24,
  parameter int unsigned ESTW = OPW / 2 + 1,
  parameter int unsigned CW   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            done_i,
  input logic [ESTW-1:0] est_i,
  input state_e          state_i,
  input logic [CW-1:0]   cnt_i
);
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R8
  est_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(est_i));

  // R9
  est_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    est_i < ESTW'(1 << (OPW / 2)));

  // R7
  no_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_COUNT) |=> (state_i != ST_IDLE));

  // R4
  lz_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_COUNT) |-> (cnt_i < CW'(OPW)));

  // R2
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SHIFT && cnt_i != '0) |=> (cnt_i == CW'($past(cnt_i) - 1'b1)));
endmodule

bind sqrt_seed_gen sqe_chk #(.OPW(OPW), .ESTW(ESTW), .CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done_i  (done_o),
  .est_i   (est_o),
  .state_i (state_w),
  .cnt_i   (cnt_w)
);

// File: tb/tb_sqrt_seed_gen.sv
module tb_sqrt_seed_gen;
  localparam int OPW  = 24;
  localparam int ESTW = 13;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [OPW-1:0]  opnd_i = '0;
  logic [ESTW-1:0] est_o;
  logic            done_o;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #10 clk_i = ~clk_i;

  sqrt_seed_gen dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .opnd_i (opnd_i),
    .est_o  (est_o),
    .done_o (done_o)
  );

  function automatic int sig_bits(input logic [OPW-1:0] a);
    int k = 0;
    for (int i = 0; i < OPW; i++) if (a[i]) k = i + 1;
    return k;
  endfunction

  function automatic int exp_est(input logic [OPW-1:0] a);
    int k, r;
    if (a == 0) return 0;
    k = sig_bits(a);
    r = int'(a >> ((k + 1) / 2));
    return (r == 0) ? 1 : r;
  endfunction

  function automatic int exp_lat(input logic [OPW-1:0] a);
    int k;
    if (a == 0) return 0;
    k = sig_bits(a);
    return (OPW - k) + (k + 1) / 2 + 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // disturb: pulse start with another operand while busy (R7)
  task automatic run(input logic [OPW-1:0] a, input bit disturb, input string req);
    int n = 0;
    bit seen = 0;
    @(negedge clk_i);
    opnd_i  = a;
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    opnd_i  = OPW'($urandom);   // R8: change after capture
    if (done_o) seen = 1;
    while (!seen && n < 60) begin
      if (disturb && n == 3) begin
        start_i = 1'b1;
        opnd_i  = OPW'($urandom) | 24'h1;
      end else begin
        start_i = 1'b0;
      end
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      if (done_o) seen = 1;
    end
    start_i = 1'b0;
    check({req, " latency"}, n, exp_lat(a));
    check({req, " estimate"}, int'(est_o), exp_est(a));
    check("R9 range", int'(est_o < 13'd4096), 1);
    @(negedge clk_i);
    check("R6 single pulse", int'(done_o), 0);
    check("R8 hold", int'(est_o), exp_est(a));
  endtask

  initial begin
    repeat (2000000 / 20) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R1 reset done", int'(done_o), 0);
    check("R1 reset est", int'(est_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run(24'h000001, 0, "R3 one");
    run(24'hFFFFFF, 0, "R4 all ones");
    run(24'h000000, 0, "R5 zero");
    run(24'h000002, 0, "R2 two");
    run(24'h000003, 0, "R2 three");
    run(24'h000000, 0, "R5 zero again");
    for (int i = 0; i < OPW; i++) run(OPW'(1) << i, 0, "R2 single bit");
    run(24'h800000, 1, "R7 busy start");
    for (int i = 0; i < 120; i++) begin
      logic [OPW-1:0] a;
      a = OPW'($urandom) >> ($urandom % OPW);
      run(a, (i % 4) == 0, "R2 random");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule